// File: doc/BRIEF.md
# Ping-Pong Framebuffer Swap Controller

This block arbitrates two framebuffer banks between a video scan-out engine and a drawing agent. The scan-out address logic always reads the bank named by the front select, and the drawing agent always writes the opposite bank. Exchanging the roles of the banks only changes a one-bit pointer. No pixel data is ever copied.

When the drawing agent has finished an image, it pulses a swap request. The controller then raises a pending flag. While that flag is high, every write lane toward the back bank is forced off, and each refused attempt is reported with a one-cycle reject pulse. In the normal mode the exchange takes place on the rising edge of vertical blanking, so the new front bank is settled before the first visible line. No displayed frame mixes two images. An optional immediate mode exchanges the banks one cycle after the request, whatever the state of blanking, and accepts tearing. The pending flag clears on the same edge as the exchange, and the back bank is then open for new drawing.

Top module: `fb_swap_ctrl`

## Requirements
- R1: While rst_ni is low, front_sel_o is 0, back_sel_o is 1, pending_o is 0 and wr_reject_o is 0, and these values take effect asynchronously.
- R2: back_sel_o is always the inverse of front_sel_o.
- R3: A clock edge with swap_req_i high and pending_o low sets pending_o and leaves front_sel_o unchanged.
- R4: With immediate_mode_i low and pending_o high, front_sel_o toggles on the first edge where vblank_i is 1 after having been 0 on the previous edge. A vblank_i level that stays high causes no further toggle.
- R5: pending_o returns to 0 on the same edge on which front_sel_o toggles.
- R6: While pending_o is high, all bits of wr_en_o are 0. While pending_o is low, wr_en_o equals wr_en_i lane by lane (bit n gates lane n).
- R7: A swap request made while pending_o is high is ignored. It neither causes an extra toggle nor keeps the flag set after the swap.
- R8: wr_reject_o is high for exactly the one cycle that follows an edge at which pending_o was high and any bit of wr_en_i was high. Otherwise it is low.
- R9: With immediate_mode_i high and pending_o high, front_sel_o toggles at the next edge regardless of vblank_i.
- R10: A request that arrives on the same edge as a vblank_i rise while pending_o is low only sets pending_o. The swap waits for the following rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| swap_req_i | input | 1 | Swap request strobe from the drawing agent |
| vblank_i | input | 1 | Vertical blanking level from the timing generator |
| immediate_mode_i | input | 1 | 1: swap without waiting for blanking (tearing allowed) |
| wr_en_i | input | WE_W | Write-enable lanes requested by the drawing agent |
| front_sel_o | output | 1 | Bank read by scan-out |
| back_sel_o | output | 1 | Bank targeted by the writer |
| pending_o | output | 1 | Swap requested but not yet applied |
| wr_en_o | output | WE_W | Gated write-enable lanes toward the back bank |
| wr_reject_o | output | 1 | One-cycle pulse for each refused write attempt |

## Verification
The swap is driven by request pulses placed before a blanking rise, during a long blanking level, and on the very edge of a rise. These cases separate true edge detection from level sensitivity and show how a request that coincides with a rise is handled. Repeated requests while a swap is pending show whether the flag ignores them. Write bursts issued during and after the pending window, in both swap modes, show whether gating and the reject pulse track the flag edge by edge. An asynchronous reset applied mid-swap shows that the pointer and the flag return to their initial state.

// File: rtl/fbsw_pkg.sv
package fbsw_pkg;

  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_e;

  function automatic bank_e other_bank(bank_e b);
    return bank_e'(~b);
  endfunction

endpackage

// File: rtl/fbsw_vblank_edge.sv
module fbsw_vblank_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vblank_i,
  output logic rise_o
);

  logic vblank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vblank_q <= 1'b0;
    else         vblank_q <= vblank_i;
  end

  assign rise_o = vblank_i & ~vblank_q;

  // a held level never yields two consecutive rises
  assert_single_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/fbsw_swap_ctrl.sv
module fbsw_swap_ctrl
  import fbsw_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  swap_req_i,
  input  logic  vblank_rise_i,
  input  logic  immediate_i,
  output bank_e front_o,
  output logic  pending_o
);

  bank_e front_q;
  logic  pending_q, pending_d, swap_now;

  // exchange is only ever armed by a previously latched request
  assign swap_now = pending_q & (vblank_rise_i | immediate_i);

  always_comb begin
    pending_d = pending_q;
    if (swap_now)        pending_d = 1'b0;
    else if (swap_req_i) pending_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_q   <= BANK_LO;
      pending_q <= 1'b0;
    end else begin
      pending_q <= pending_d;
      if (swap_now) front_q <= other_bank(front_q);
    end
  end

  assign front_o   = front_q;
  assign pending_o = pending_q;

  assert_swap_needs_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (front_q != $past(front_q)) |-> $past(pending_q) && ($past(vblank_rise_i) || $past(immediate_i)));

  assert_pending_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q && vblank_rise_i |=> !pending_q && (front_q != $past(front_q)));

  assert_req_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q && !vblank_rise_i && !immediate_i |=> pending_q && $stable(front_q));

  assert_immediate_swap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q && immediate_i |=> !pending_q && (front_q != $past(front_q)));

  assert_req_sets_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_q && swap_req_i |=> pending_q && $stable(front_q));

endmodule

// File: rtl/fbsw_write_gate.sv
module fbsw_write_gate #(
  parameter int unsigned WE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pending_i,
  input  logic [WE_W-1:0] wr_en_i,
  output logic [WE_W-1:0] wr_en_o,
  output logic            wr_reject_o
);

  logic reject_q;

  for (genvar g = 0; g < WE_W; g++) begin : g_lane
    assign wr_en_o[g] = wr_en_i[g] & ~pending_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reject_q <= 1'b0;
    else         reject_q <= pending_i & (|wr_en_i);
  end

  assign wr_reject_o = reject_q;

  assert_no_write_when_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_i |-> (wr_en_o == '0));

  assert_reject_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_i && (|wr_en_i) |=> wr_reject_o);

  assert_no_spurious_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pending_i && (|wr_en_i)) |=> !wr_reject_o);

endmodule

// File: rtl/fb_swap_ctrl.sv
module fb_swap_ctrl
  import fbsw_pkg::*;
#(
  parameter int unsigned WE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            swap_req_i,
  input  logic            vblank_i,
  input  logic            immediate_mode_i,
  input  logic [WE_W-1:0] wr_en_i,
  output logic            front_sel_o,
  output logic            back_sel_o,
  output logic            pending_o,
  output logic [WE_W-1:0] wr_en_o,
  output logic            wr_reject_o
);

  logic  vblank_rise;
  logic  pending;
  bank_e front_bank;

  fbsw_vblank_edge i_vblank_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vblank_i (vblank_i),
    .rise_o   (vblank_rise)
  );

  fbsw_swap_ctrl i_swap_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .swap_req_i    (swap_req_i),
    .vblank_rise_i (vblank_rise),
    .immediate_i   (immediate_mode_i),
    .front_o       (front_bank),
    .pending_o     (pending)
  );

  fbsw_write_gate #(.WE_W(WE_W)) i_write_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pending_i   (pending),
    .wr_en_i     (wr_en_i),
    .wr_en_o     (wr_en_o),
    .wr_reject_o (wr_reject_o)
  );

  assign front_sel_o = front_bank;
  assign back_sel_o  = other_bank(front_bank);
  assign pending_o   = pending;

  assert_banks_differ_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    back_sel_o != front_sel_o);

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !front_sel_o && !pending_o && !wr_reject_o);

endmodule

// File: tb/test_fb_swap_ctrl.sv
module test_fb_swap_ctrl;

  localparam int unsigned WE_W = 4;
  localparam int unsigned NVEC = 22;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic swap_req = 1'b0, vblank = 1'b0, imm = 1'b0;
  logic [WE_W-1:0] wr_en_in = '0;
  logic front_sel, back_sel, pending, wr_reject;
  logic [WE_W-1:0] wr_en_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fb_swap_ctrl #(.WE_W(WE_W)) i_fb_swap_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .swap_req_i(swap_req), .vblank_i(vblank),
    .immediate_mode_i(imm), .wr_en_i(wr_en_in), .front_sel_o(front_sel),
    .back_sel_o(back_sel), .pending_o(pending), .wr_en_o(wr_en_out),
    .wr_reject_o(wr_reject)
  );

  // [13] req [12] vblank [11] imm [10:7] wr_en_i | [6] front [5] pending [4:1] wr_en_o [0] reject
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0,1'b0,1'b0,4'hF, 1'b0,1'b0,4'hF,1'b0}, //  0 R6 open gate
    {1'b1,1'b0,1'b0,4'h0, 1'b0,1'b1,4'h0,1'b0}, //  1 R3 request
    {1'b0,1'b0,1'b0,4'h3, 1'b0,1'b1,4'h0,1'b1}, //  2 R6 R8 refused write
    {1'b1,1'b0,1'b0,4'h0, 1'b0,1'b1,4'h0,1'b0}, //  3 R7 repeat request
    {1'b0,1'b1,1'b0,4'h0, 1'b1,1'b0,4'h0,1'b0}, //  4 R4 R5 swap at rise
    {1'b0,1'b1,1'b0,4'h5, 1'b1,1'b0,4'h5,1'b0}, //  5 R6 gate reopened
    {1'b1,1'b1,1'b0,4'h0, 1'b1,1'b1,4'h0,1'b0}, //  6 R3 request during level
    {1'b0,1'b1,1'b0,4'h0, 1'b1,1'b1,4'h0,1'b0}, //  7 R4 level, no swap
    {1'b0,1'b0,1'b0,4'h0, 1'b1,1'b1,4'h0,1'b0}, //  8
    {1'b0,1'b1,1'b0,4'h0, 1'b0,1'b0,4'h0,1'b0}, //  9 R4 next rise swaps
    {1'b0,1'b0,1'b0,4'h0, 1'b0,1'b0,4'h0,1'b0}, // 10
    {1'b1,1'b1,1'b0,4'h0, 1'b0,1'b1,4'h0,1'b0}, // 11 R10 request on rise
    {1'b0,1'b1,1'b0,4'h0, 1'b0,1'b1,4'h0,1'b0}, // 12 R10 waits
    {1'b0,1'b0,1'b0,4'h0, 1'b0,1'b1,4'h0,1'b0}, // 13
    {1'b0,1'b1,1'b0,4'h0, 1'b1,1'b0,4'h0,1'b0}, // 14 R10 following rise
    {1'b1,1'b0,1'b1,4'h0, 1'b1,1'b1,4'h0,1'b0}, // 15 R9 request, immediate
    {1'b0,1'b0,1'b1,4'h0, 1'b0,1'b0,4'h0,1'b0}, // 16 R9 swap without vblank
    {1'b0,1'b0,1'b1,4'hA, 1'b0,1'b0,4'hA,1'b0}, // 17 R6
    {1'b1,1'b0,1'b0,4'h0, 1'b0,1'b1,4'h0,1'b0}, // 18 R3
    {1'b0,1'b0,1'b0,4'hF, 1'b0,1'b1,4'h0,1'b1}, // 19 R8 reject
    {1'b0,1'b0,1'b0,4'h0, 1'b0,1'b1,4'h0,1'b0}, // 20 R8 single cycle
    {1'b0,1'b0,1'b1,4'h0, 1'b1,1'b0,4'h0,1'b0}  // 21 R9 mode raised while pending
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // reset state R1
    #35;
    check("R1 front", {3'b0, front_sel}, 4'h0);
    check("R1 back",  {3'b0, back_sel},  4'h1);
    check("R1 pending", {3'b0, pending}, 4'h0);
    check("R1 reject", {3'b0, wr_reject}, 4'h0);
    rst_ni = 1'b1;
    #10;

    // vector walk
    for (int i = 0; i < NVEC; i++) begin
      swap_req = VEC[i][13];
      vblank   = VEC[i][12];
      imm      = VEC[i][11];
      wr_en_in = VEC[i][10:7];
      step();
      check("R4 front",   {3'b0, front_sel}, {3'b0, VEC[i][6]});
      check("R2 back",    {3'b0, back_sel},  {3'b0, ~VEC[i][6]});
      check("R3 pending", {3'b0, pending},   {3'b0, VEC[i][5]});
      check("R6 wr_en",   wr_en_out,         VEC[i][4:1]);
      check("R8 reject",  {3'b0, wr_reject}, {3'b0, VEC[i][0]});
    end

    // R1: asynchronous reset while pending with a reject in flight
    swap_req = 1'b1; imm = 1'b0; vblank = 1'b0; wr_en_in = '0;
    step();
    swap_req = 1'b0; wr_en_in = 4'h1;
    step();
    check("R8 reject before reset", {3'b0, wr_reject}, 4'h1);
    #5;
    rst_ni = 1'b0;
    #1;
    check("R1 async front",   {3'b0, front_sel}, 4'h0);
    check("R1 async pending", {3'b0, pending},   4'h0);
    check("R1 async reject",  {3'b0, wr_reject}, 4'h0);
    check("R2 async back",    {3'b0, back_sel},  4'h1);
    wr_en_in = '0;
    #20;
    rst_ni = 1'b1;

    // R5 R7: request repeated on the swap edge must not re-arm the flag
    swap_req = 1'b1;
    step();
    vblank = 1'b1;
    step();
    check("R5 pending cleared", {3'b0, pending},   4'h0);
    check("R7 single toggle",   {3'b0, front_sel}, 4'h1);
    swap_req = 1'b0;
    step();
    check("R7 flag stays low",  {3'b0, pending},   4'h0);
    check("R6 gate open", wr_en_out, 4'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule